// File: doc/BRIEF.md
# Interleaved Block Refill Controller

This block fills one cache line from a word-interleaved memory made of several banks. The cache hands it a block request carrying a word address. Once the request is taken, the controller spends one cycle broadcasting the block address to every bank at once. All banks then run their array access side by side, so the access latency is paid only once. After that the words of the line are returned over a single one-word bus, one per cycle, lowest bank first.

Each bank is modelled inside the block as a fixed-latency array. Its content is a computed pattern of the word address. With the default parameters (four words, fifteen-cycle access) a refill occupies 1 + 15 + 4 = 20 cycles.

The request side is a valid/ready handshake. A request is taken on a rising clock edge where both `req_valid` and `req_ready` are high. While a refill is in flight `req_ready` stays low, so a requester holding `req_valid` high is stalled until the controller is idle again, and its address is sampled only at the accepting edge. The word return has no back-pressure: the cache must take each word in the cycle `word_valid` is high.

Top module: `interleaved_refill`

## Requirements
- R1: After reset, `req_ready` is 1, and `word_valid` and `done` are 0.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both 1. From the accepting edge until the last word has been captured, `req_ready` is 0, and any `req_valid` activity in that window leaves the refill in progress unchanged.
- R3: For a request accepted at edge n, word 0 is on the bus in the cycle between edges n+1+LAT_CYC and n+2+LAT_CYC. This is one address cycle followed by LAT_CYC cycles of parallel access, which is edge n+16 with the defaults.
- R4: Words appear with `word_valid` high on WORDS consecutive cycles, with `word_index` counting 0,1,...,WORDS-1 in that order. `word_valid` is 0 in every other cycle.
- R5: The word with index k is read from bank k at word address A+k, where A is the block base address. Its value is ((A+k) * 0x9E3779B1) XOR 0xA5A50F0F, computed modulo 2^32.
- R6: `done` is 1 exactly in the cycle that carries the word with index WORDS-1, and is 0 otherwise.
- R7: The last word is captured at edge n+1+LAT_CYC+WORDS, which is edge n+20 with the defaults. `req_ready` is 1 in the cycle after that edge.
- R8: The low log2(WORDS) bits of `req_addr` are ignored: the base A is `req_addr` with those bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Block request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | ADDR_W | Word address of the block to refill |
| word_valid | output | 1 | A refill word is on the return bus |
| word_index | output | log2(WORDS) | Position of the current word in the block |
| word_data | output | DATA_W | Returned word |
| done | output | 1 | Last word of the block is on the bus |

## Verification
The hardest situation to reach is a requester that raises `req_valid` while a refill is already running. It must be stalled without disturbing the words still to come, and then taken on the first idle edge with no gap. The stimulus reaches this in two ways. It raises the next request on the cycle right after an acceptance and holds it until taken. It also drops a short `req_valid` pulse with a different address into the middle of a refill. A behavioural model that counts cycles since acceptance predicts every output on every clock. An unaligned request address exercises the base-address masking.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ADDR   = 2'd1,
    ST_ACCESS = 2'd2,
    ST_XFER   = 2'd3
  } refill_state_e;

  // Content stored in the modelled arrays at a given word address.
  function automatic logic [31:0] fill_pattern(input logic [31:0] waddr);
    return (waddr * 32'h9E37_79B1) ^ 32'hA5A5_0F0F;
  endfunction

endpackage

// File: rtl/refill_bank.sv
module refill_bank
  import refill_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int LAT_CYC = 15,
  parameter int BANKS   = 4,
  parameter int BANK_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] blk_addr,
  output logic              fill_now,
  output logic [DATA_W-1:0] rd_data
);

  localparam int CNT_W = $clog2(LAT_CYC + 1);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(BANKS - 1);
  localparam logic [ADDR_W-1:0] MY_OFF   = ADDR_W'(BANK_ID);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] waddr_q;

  // The bank is in the final cycle of its array access.
  assign fill_now = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      waddr_q <= '0;
      rd_data <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      cnt_q   <= CNT_W'(LAT_CYC - 1);
      waddr_q <= (blk_addr & ~OFF_MASK) | MY_OFF;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q  <= 1'b0;
        rd_data <= DATA_W'(fill_pattern(32'(waddr_q)));
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/refill_seq.sv
module refill_seq
  import refill_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORDS  = 4,
  parameter int IDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              all_fill,
  output logic              req_ready,
  output logic              bank_start,
  output logic [ADDR_W-1:0] blk_addr,
  output logic              xfer,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  refill_state_e     state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;

  assign req_ready  = (state_q == ST_IDLE);
  assign bank_start = (state_q == ST_ADDR);
  assign xfer       = (state_q == ST_XFER);
  assign idx        = idx_q;
  assign blk_addr   = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      addr_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            state_q <= ST_ADDR;
            addr_q  <= req_addr;
          end
        end
        ST_ADDR: begin
          state_q <= ST_ACCESS;
        end
        ST_ACCESS: begin
          if (all_fill) begin
            state_q <= ST_XFER;
            idx_q   <= '0;
          end
        end
        ST_XFER: begin
          if (idx_q == LAST_IDX) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/refill_return.sv
module refill_return #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = $clog2(WORDS)
) (
  input  logic [WORDS-1:0][DATA_W-1:0] bank_data,
  input  logic                         xfer,
  input  logic [IDX_W-1:0]             idx,
  output logic                         word_valid,
  output logic [IDX_W-1:0]             word_index,
  output logic [DATA_W-1:0]            word_data,
  output logic                         done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  always_comb begin
    word_valid = xfer;
    word_index = xfer ? idx : '0;
    word_data  = xfer ? bank_data[idx] : '0;
    done       = xfer && (idx == LAST_IDX);
  end

endmodule

// File: rtl/interleaved_refill.sv
module interleaved_refill
  import refill_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int WORDS   = 4,
  parameter int LAT_CYC = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  output logic                     word_valid,
  output logic [$clog2(WORDS)-1:0] word_index,
  output logic [DATA_W-1:0]        word_data,
  output logic                     done
);

  localparam int IDX_W = $clog2(WORDS);

  logic                         bank_start;
  logic [ADDR_W-1:0]            blk_addr;
  logic                         xfer;
  logic [IDX_W-1:0]             idx;
  logic [WORDS-1:0]             fill_vec;
  logic [WORDS-1:0][DATA_W-1:0] bank_data;
  logic                         all_fill;

  assign all_fill = &fill_vec;

  refill_seq #(
    .ADDR_W(ADDR_W),
    .WORDS (WORDS),
    .IDX_W (IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .all_fill  (all_fill),
    .req_ready (req_ready),
    .bank_start(bank_start),
    .blk_addr  (blk_addr),
    .xfer      (xfer),
    .idx       (idx)
  );

  for (genvar b = 0; b < WORDS; b++) begin : g_bank
    refill_bank #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LAT_CYC(LAT_CYC),
      .BANKS  (WORDS),
      .BANK_ID(b)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (bank_start),
      .blk_addr(blk_addr),
      .fill_now(fill_vec[b]),
      .rd_data (bank_data[b])
    );
  end

  refill_return #(
    .DATA_W(DATA_W),
    .WORDS (WORDS),
    .IDX_W (IDX_W)
  ) u_ret (
    .bank_data (bank_data),
    .xfer      (xfer),
    .idx       (idx),
    .word_valid(word_valid),
    .word_index(word_index),
    .word_data (word_data),
    .done      (done)
  );

endmodule

// File: rtl/refill_checker.sv
module refill_checker #(
  parameter int WORDS   = 4,
  parameter int LAT_CYC = 15,
  parameter int IDX_W   = $clog2(WORDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             word_valid,
  input logic [IDX_W-1:0] word_index,
  input logic             done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);
  localparam logic [15:0] FIRST_AT = 16'(1 + LAT_CYC);

  logic [15:0] since_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_acc <= '0;
    else if (req_valid && req_ready) since_acc <= '0;
    else if (since_acc != 16'hFFFF) since_acc <= since_acc + 1'b1;
  end

  // R2: once taken, the controller stops offering ready
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R2: no new request can be taken while words are returning
  a_r2_busy_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !req_ready);

  // R3: first word appears after the address cycle and the access latency
  a_r3_first_word_time: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && (word_index == '0) |-> since_acc == FIRST_AT);

  // R4: burst starts at index zero
  a_r4_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> word_index == '0);

  // R4: consecutive words with increasing index
  a_r4_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && (word_index != LAST_IDX) |=>
      word_valid && (word_index == $past(word_index) + 1'b1));

  // R6: done marks the last word only
  a_r6_done_with_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> word_valid && (word_index == LAST_IDX));

  // R7: ready returns right after the last word
  a_r7_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready && !word_valid);

endmodule

bind interleaved_refill refill_checker #(
  .WORDS  (WORDS),
  .LAT_CYC(LAT_CYC),
  .IDX_W  ($clog2(WORDS))
) u_refill_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .word_valid(word_valid),
  .word_index(word_index),
  .done      (done)
);

// File: tb/interleaved_refill_test.sv
`timescale 1ns/1ps
module interleaved_refill_test;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int WORDS  = 4;
  localparam int LAT    = 15;
  localparam int FIRST  = 1 + LAT;
  localparam int TOTAL  = 1 + LAT + WORDS;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_ready;
  logic              word_valid;
  logic [1:0]        word_index;
  logic [DATA_W-1:0] word_data;
  logic              done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  // model state
  bit m_busy = 1'b0;
  int m_t    = 0;
  int m_base = 0;
  int m_acc  = 0;
  bit m_unal = 1'b0;
  bit m_was_done = 1'b0;

  always #5 clk = ~clk;

  interleaved_refill #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .LAT_CYC(LAT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .word_valid(word_valid), .word_index(word_index),
    .word_data(word_data), .done(done)
  );

  function automatic logic [31:0] mem_word(input int w);
    logic [31:0] a;
    a = 32'(w);
    return (a * 32'h9E3779B1) ^ 32'hA5A50F0F;
  endfunction

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d",
               req, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 1'b0;
      m_t = 0;
    end else if (!m_busy) begin
      if (req_valid) begin
        m_busy = 1'b1;
        m_t    = 0;
        m_base = int'(req_addr) & ~(WORDS - 1);
        m_unal = (int'(req_addr) & (WORDS - 1)) != 0;
        m_acc  = cyc;
      end
    end else begin
      m_t++;
      if (m_t == TOTAL) m_busy = 1'b0;
    end
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected end before 20000", cyc);
      summary();
    end
  end

  // compare every output against the model away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_wv, e_done;
      int e_idx;
      e_wv   = m_busy && m_t >= FIRST && m_t < TOTAL;
      e_idx  = e_wv ? m_t - FIRST : 0;
      e_done = e_wv && e_idx == WORDS - 1;
      check(m_was_done ? "R7" : "R2", "req_ready", req_ready, !m_busy);
      check((m_busy && m_t == FIRST) ? "R3" : "R4", "word_valid", word_valid, e_wv);
      check("R4", "word_index", word_index, e_idx);
      if (e_wv)
        check(m_unal ? "R8" : "R5", "word_data", word_data, mem_word(m_base + e_idx));
      check("R6", "done", done, e_done);
      if (done && e_done)
        check("R7", "refill length", cyc - m_acc + 1, 20);
      m_was_done = e_done;
    end
  end

  task automatic issue(input logic [ADDR_W-1:0] a);
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    req_addr  = $urandom_range(0, 65535);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    idle(3);
    #1;
    // R1: outputs during and right after reset
    check("R1", "req_ready in reset", req_ready, 1);
    check("R1", "word_valid in reset", word_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "req_ready after reset", req_ready, 1);
    check("R1", "done after reset", done, 0);
    check("R1", "word_valid after reset", word_valid, 0);

    // R3 R4 R5 R6 R7: a single aligned refill
    issue(16'h0040);
    wait_idle();
    idle(2);

    // R8: unaligned address, low bits must be dropped
    issue(16'h1237);
    wait_idle();

    // R2: back-to-back requests, the second held off until idle
    issue(16'hFFFC);
    issue(16'h0000);
    issue(16'h8001);

    // R2: short pulse during a refill must be ignored
    issue(16'h2468);
    idle(5);
    #1;
    req_valid = 1'b1;
    req_addr  = 16'h7770;
    @(posedge clk); #1;
    req_valid = 1'b0;
    wait_idle();
    idle(3);

    // another refill after the ignored pulse
    issue(16'h5556);
    wait_idle();
    idle(4);
    summary();
  end

endmodule